// File: doc/BRIEF.md
# Saturating Vector Narrowing Unit

This datapath takes a 128-bit source vector made of equal-width integer elements and halves the width of every element. The narrowed elements form a 64-bit result. That result is placed in one of two ways. It can go into the low half of the destination, with the high half forced to zero. It can also go into the high half, with the low half taken from the prior destination value. Narrowing either cuts each element down to its low half or clamps it into the range of the narrow type. The clamping can be signed-to-signed, signed-to-unsigned or unsigned-to-unsigned.

The result path is purely combinational, so the new destination value is ready in the same cycle as the operands. A single registered bit records whether any lane was clamped by an enabled operation. That bit stays set across later operations until software-visible logic upstream pulses the clear input.

A typical use is packing wide accumulators into narrow samples. Two operations build one full 128-bit vector: a low-half write first, then a high-half write that carries the first result in on the keep input.

Top module: `vnarrow_unit`

## Requirements
- R1: When `upper_sel` is 0, `dst_out[63:0]` holds the narrowed vector and `dst_out[127:64]` is zero.
- R2: When `upper_sel` is 1, `dst_out[127:64]` holds the narrowed vector and `dst_out[63:0]` equals `dst_keep`.
- R3: Mode code 0 (truncate) gives each result lane the low half of its source element, and it never reports a clamp.
- R4: Mode code 1 (signed to signed) keeps values that fit the narrow signed range. A larger value becomes the narrow signed maximum and a smaller one becomes the narrow signed minimum, and both count as a clamp.
- R5: Mode code 2 (signed to unsigned) turns any negative source into 0 and any source above the narrow unsigned maximum into that maximum; both count as a clamp. Other values pass unchanged.
- R6: Mode code 3 (unsigned to unsigned) turns any source above the narrow unsigned maximum into all ones and counts it as a clamp. Other values pass unchanged.
- R7: Size code 0 means 16-bit elements, giving eight 8-bit result lanes. Code 1 means 32-bit elements, giving four 16-bit lanes. Codes 2 and 3 both mean 64-bit elements, giving two 32-bit lanes. Result lane i comes from source element i and sits at bits [i*h +: h] of the narrowed vector, where h is the narrow width.
- R8: At a rising clock edge where `op_en` is 1 and at least one lane clamps, `sat_flag` becomes 1.
- R9: `sat_flag` stays 1 until an edge with `sat_clr` high. At that edge it becomes 0, unless the same edge also sets it under R8, in which case setting wins.
- R10: At an edge with `op_en` low and `sat_clr` low, `sat_flag` does not change, whatever the operands. `dst_out` is still computed.
- R11: While `rst_n` is low, and right after it rises, `sat_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_vec | input | 128 | Source vector of wide elements |
| dst_keep | input | 64 | Prior destination low half, kept in upper placement |
| elem_sz | input | 2 | Source element size code |
| mode | input | 2 | Narrowing mode code |
| upper_sel | input | 1 | 1 selects high-half placement |
| op_en | input | 1 | Operation is valid and may set the flag |
| sat_clr | input | 1 | Clears the sticky flag |
| dst_out | output | 128 | New destination value |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
The bench builds the unit with its default 128-bit vector width. At that width, each mode gets every one of the 65536 possible 16-bit element codes, eight lanes per operation, with the flag cleared every cycle so that it mirrors the clamp result of each single operation. The 32-bit and 64-bit sizes cannot be swept that way. For those, the bench rotates a set of edge values through the lanes: one either side of each narrow range limit, zero, and the wide extremes. It then adds randomly shifted and inverted operands, with placement, enable and clear varied. Short directed sequences exercise the set, hold, clear and set-beats-clear behaviour of the flag.

// File: rtl/vn_pkg.sv
package vn_pkg;

  // Narrowing mode encoding, shared by the lanes and the top level
  typedef enum logic [1:0] {
    NM_TRUNC = 2'd0,
    NM_SS    = 2'd1,
    NM_SU    = 2'd2,
    NM_UU    = 2'd3
  } nmode_t;

  // Number of source element sizes the unit supports (16, 32, 64)
  localparam int N_SZ = 3;
  localparam int BASE_ELEM_W = 16;

  // Map the size code onto a bank index; code 3 aliases the widest bank
  function automatic logic [1:0] size_to_bank(input logic [1:0] code);
    logic [1:0] idx;
    case (code)
      2'd0:    idx = 2'd0;
      2'd1:    idx = 2'd1;
      default: idx = 2'd2;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/vn_lane.sv
module vn_lane
  import vn_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  nmode_t               mode,
  input  logic [SRC_W-1:0]     src,
  output logic [SRC_W/2-1:0]   res,
  output logic                 sat
);

  localparam int DST_W = SRC_W / 2;

  // Source fits in the narrow signed type: all bits from DST_W-1 upward agree
  function automatic logic fits_signed(input logic [SRC_W-1:0] v);
    logic [SRC_W-DST_W:0] top;
    top = v[SRC_W-1:DST_W-1];
    return (top == '0) || (top == '1);
  endfunction

  // Source fits in the narrow unsigned type: upper half is all zero
  function automatic logic fits_unsigned(input logic [SRC_W-1:0] v);
    return v[SRC_W-1:DST_W] == '0;
  endfunction

  function automatic logic [DST_W-1:0] signed_limit(input logic neg);
    return neg ? {1'b1, {(DST_W-1){1'b0}}} : {1'b0, {(DST_W-1){1'b1}}};
  endfunction

  // Named internal events
  logic is_neg;
  logic fit_s;
  logic fit_u;
  logic [DST_W-1:0] lo_half;

  assign is_neg  = src[SRC_W-1];
  assign fit_s   = fits_signed(src);
  assign fit_u   = fits_unsigned(src);
  assign lo_half = src[DST_W-1:0];

  always_comb begin
    res = lo_half;
    sat = 1'b0;
    case (mode)
      NM_SS: begin
        if (!fit_s) begin
          sat = 1'b1;
          res = signed_limit(is_neg);
        end
      end
      NM_SU: begin
        if (is_neg) begin
          sat = 1'b1;
          res = '0;
        end else if (!fit_u) begin
          sat = 1'b1;
          res = '1;
        end
      end
      NM_UU: begin
        if (!fit_u) begin
          sat = 1'b1;
          res = '1;
        end
      end
      default: begin
        res = lo_half;
        sat = 1'b0;
      end
    endcase
  end

  always_comb begin
    // R4
    if (mode == NM_SS && sat)
      ss_clamp_sign_chk: assert (res[DST_W-1] == src[SRC_W-1])
        else $error("signed clamp picked the wrong limit");
    // R5
    if (mode == NM_SU && src[SRC_W-1])
      su_neg_zero_chk: assert (res == '0)
        else $error("negative source did not clamp to zero");
    // R6
    if (mode == NM_UU && sat)
      uu_clamp_max_chk: assert (&res)
        else $error("unsigned clamp is not all ones");
  end

endmodule

// File: rtl/vn_lane_bank.sv
module vn_lane_bank
  import vn_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int SRC_W = 16
) (
  input  nmode_t               mode,
  input  logic [VEC_W-1:0]     src,
  output logic [VEC_W/2-1:0]   res,
  output logic                 sat_any
);

  localparam int DST_W   = SRC_W / 2;
  localparam int N_LANES = VEC_W / SRC_W;

  logic [N_LANES-1:0] lane_sat;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    vn_lane #(.SRC_W(SRC_W)) u_lane (
      .mode (mode),
      .src  (src[i*SRC_W +: SRC_W]),
      .res  (res[i*DST_W +: DST_W]),
      .sat  (lane_sat[i])
    );
  end

  assign sat_any = |lane_sat;

endmodule

// File: rtl/vn_place.sv
module vn_place #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W/2-1:0] narrow,
  input  logic [VEC_W/2-1:0] keep_lo,
  input  logic               upper,
  output logic [VEC_W-1:0]   dst
);

  localparam int HALF = VEC_W / 2;

  always_comb begin
    if (upper) dst = {narrow, keep_lo};
    else       dst = {{HALF{1'b0}}, narrow};
  end

endmodule

// File: rtl/vn_sticky.sv
module vn_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic op_en,
  input  logic sat_evt,
  input  logic sat_clr,
  output logic flag
);

  logic set_now;
  assign set_now = op_en & sat_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~sat_clr) | set_now;
  end

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> flag);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !sat_clr) |=> flag);

  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !set_now) |=> !flag);

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_en && !sat_clr) |=> $stable(flag));

endmodule

// File: rtl/vnarrow_unit.sv
module vnarrow_unit
  import vn_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VEC_W-1:0]   src_vec,
  input  logic [VEC_W/2-1:0] dst_keep,
  input  logic [1:0]         elem_sz,
  input  logic [1:0]         mode,
  input  logic               upper_sel,
  input  logic               op_en,
  input  logic               sat_clr,
  output logic [VEC_W-1:0]   dst_out,
  output logic               sat_flag
);

  localparam int HALF = VEC_W / 2;

  nmode_t mode_e;
  assign mode_e = nmode_t'(mode);

  logic [HALF-1:0] bank_res [N_SZ];
  logic            bank_sat [N_SZ];

  // One bank of lanes per element size; all run in parallel
  for (genvar g = 0; g < N_SZ; g++) begin : g_bank
    vn_lane_bank #(
      .VEC_W (VEC_W),
      .SRC_W (BASE_ELEM_W << g)
    ) u_bank (
      .mode    (mode_e),
      .src     (src_vec),
      .res     (bank_res[g]),
      .sat_any (bank_sat[g])
    );
  end

  logic [1:0]      bank_idx;
  logic [HALF-1:0] sel_res;
  logic            sel_sat;

  assign bank_idx = size_to_bank(elem_sz);

  always_comb begin
    sel_res = bank_res[0];
    sel_sat = bank_sat[0];
    for (int b = 1; b < N_SZ; b++) begin
      if (bank_idx == b[1:0]) begin
        sel_res = bank_res[b];
        sel_sat = bank_sat[b];
      end
    end
  end

  vn_place #(.VEC_W(VEC_W)) u_place (
    .narrow  (sel_res),
    .keep_lo (dst_keep),
    .upper   (upper_sel),
    .dst     (dst_out)
  );

  vn_sticky u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_en   (op_en),
    .sat_evt (sel_sat),
    .sat_clr (sat_clr),
    .flag    (sat_flag)
  );

  // R1
  lower_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upper_sel |-> (dst_out[VEC_W-1:HALF] == '0));

  // R2
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upper_sel |-> (dst_out[HALF-1:0] == dst_keep));

  // R3
  trunc_no_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == NM_TRUNC) |-> !sel_sat);

  // R1
  lower_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upper_sel |-> (dst_out[HALF-1:0] == sel_res));

endmodule

// File: tb/tb_vnarrow_unit.sv
`timescale 1ns/1ps
module tb_vnarrow_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src_vec = '0;
  logic [63:0]  dst_keep = '0;
  logic [1:0]   elem_sz = '0;
  logic [1:0]   mode = '0;
  logic         upper_sel = 1'b0;
  logic         op_en = 1'b0;
  logic         sat_clr = 1'b0;
  logic [127:0] dst_out;
  logic         sat_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_flag = 1'b0;

  always #10 clk = ~clk;

  vnarrow_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_vec   (src_vec),
    .dst_keep  (dst_keep),
    .elem_sz   (elem_sz),
    .mode      (mode),
    .upper_sel (upper_sel),
    .op_en     (op_en),
    .sat_clr   (sat_clr),
    .dst_out   (dst_out),
    .sat_flag  (sat_flag)
  );

  function automatic logic [63:0] wmask(input int w);
    if (w >= 64) return '1;
    return (64'd1 << w) - 64'd1;
  endfunction

  function automatic int size_w(input logic [1:0] sz);
    if (sz == 2'd0) return 16;
    if (sz == 2'd1) return 32;
    return 64;
  endfunction

  // Arithmetic model of one lane: range compare on integer values
  function automatic logic [31:0] ref_lane(input logic [63:0] v, input int w,
                                           input int md, output bit s);
    int h;
    longint sv, smax, smin, r;
    logic [63:0] umax;
    h    = w / 2;
    umax = wmask(h);
    smax = (longint'(1) <<< (h - 1)) - 1;
    smin = -smax - 1;
    sv   = $signed(v << (64 - w)) >>> (64 - w);
    s    = 1'b0;
    r    = longint'(v & umax);
    case (md)
      1: begin
        if (sv > smax)      begin r = smax; s = 1'b1; end
        else if (sv < smin) begin r = smin; s = 1'b1; end
        else                r = sv;
      end
      2: begin
        if (sv < 0)                     begin r = 0; s = 1'b1; end
        else if (sv > longint'(umax))   begin r = longint'(umax); s = 1'b1; end
      end
      3: begin
        if (v > umax) begin r = longint'(umax); s = 1'b1; end
      end
      default: ;
    endcase
    return 32'(r);
  endfunction

  function automatic void ref_vec(input logic [127:0] s, input logic [1:0] sz,
                                  input int md, input bit up, input logic [63:0] keep,
                                  output logic [127:0] e, output bit any);
    int w, h;
    logic [63:0] nar;
    w   = size_w(sz);
    h   = w / 2;
    nar = '0;
    any = 1'b0;
    for (int i = 0; i < 128 / w; i++) begin
      logic [63:0] v;
      logic [31:0] r;
      bit s1;
      v   = 64'(s >> (i * w)) & wmask(w);
      r   = ref_lane(v, w, md, s1);
      any = any | s1;
      nar = nar | ((64'(r) & wmask(h)) << (i * h));
    end
    e = up ? {nar, keep} : {64'd0, nar};
  endfunction

  function automatic string mode_req(input int md);
    case (md)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [63:0] edge_val(input int k, input int w);
    int h;
    longint x;
    h = w / 2;
    case (k % 12)
      0:  x = 0;
      1:  x = 1;
      2:  x = (longint'(1) <<< (h - 1)) - 1;
      3:  x = longint'(1) <<< (h - 1);
      4:  x = (longint'(1) <<< h) - 1;
      5:  x = longint'(1) <<< h;
      6:  x = -1;
      7:  x = -(longint'(1) <<< (h - 1));
      8:  x = -(longint'(1) <<< (h - 1)) - 1;
      9:  x = longint'(1) <<< (w - 1);
      10: x = (longint'(1) <<< (w - 1)) - 1;
      default: x = -(longint'(1) <<< h);
    endcase
    return 64'(x) & wmask(w);
  endfunction

  task automatic do_op(input logic [127:0] s, input logic [1:0] sz, input int md,
                       input bit up, input logic [63:0] keep, input bit en, input bit clr);
    logic [127:0] e;
    bit any;
    @(negedge clk);
    src_vec   = s;
    elem_sz   = sz;
    mode      = 2'(md);
    upper_sel = up;
    dst_keep  = keep;
    op_en     = en;
    sat_clr   = clr;
    #2;
    ref_vec(s, sz, md, up, keep, e, any);
    n_cmp++;
    if (dst_out !== e) begin
      n_bad++;
      $display("FAIL %s R7 %s sz=%0d dst_out act=%h exp=%h",
               mode_req(md), up ? "R2" : "R1", sz, dst_out, e);
    end
    @(posedge clk);
    if (clr) exp_flag = 1'b0;
    if (en && any) exp_flag = 1'b1;
    #2;
    n_cmp++;
    if (sat_flag !== exp_flag) begin
      n_bad++;
      $display("FAIL R8 R9 R10 sat_flag act=%0b exp=%0b", sat_flag, exp_flag);
    end
  endtask

  function automatic logic [127:0] fill_lanes(input int w, input int k);
    logic [127:0] s;
    s = '0;
    for (int i = 0; i < 128 / w; i++)
      s = s | (128'(edge_val(k + i, w)) << (i * w));
    return s;
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] sv;
    repeat (3) @(posedge clk);
    #2;
    n_cmp++;
    if (sat_flag !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 sat_flag in reset act=%0b exp=0", sat_flag);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    n_cmp++;
    if (sat_flag !== 1'b0 || dst_out !== 128'd0) begin
      n_bad++;
      $display("FAIL R11 R1 after reset act=%0b/%h exp=0/0", sat_flag, dst_out);
    end

    // Exhaustive 16-bit element sweep per mode; clear each op so flag mirrors clamps (R8)
    for (int md = 0; md < 4; md++) begin
      for (int base = 0; base < 65536; base += 8) begin
        sv = '0;
        for (int i = 0; i < 8; i++) sv[i*16 +: 16] = 16'(base + i);
        do_op(sv, 2'd0, md, base[3], {32'(base), 32'(~base)}, 1'b1, 1'b1);
      end
    end

    // Edge values for wider elements, all size codes including alias 3 (R7)
    for (int sz = 1; sz < 4; sz++)
      for (int md = 0; md < 4; md++)
        for (int k = 0; k < 12; k++)
          do_op(fill_lanes(size_w(2'(sz)), k), 2'(sz), md, k[0],
                {$urandom, $urandom}, 1'b1, 1'b1);

    // Sticky behaviour: R8 set, R9 hold and clear, R10 idle
    do_op(fill_lanes(32, 4), 2'd1, 3, 1'b0, '0, 1'b1, 1'b1);
    do_op('0, 2'd1, 1, 1'b0, '0, 1'b1, 1'b0);
    do_op('0, 2'd0, 0, 1'b1, '1, 1'b0, 1'b0);
    do_op(fill_lanes(16, 5), 2'd0, 1, 1'b0, '0, 1'b1, 1'b1);
    do_op('0, 2'd0, 1, 1'b0, '0, 1'b0, 1'b1);
    do_op(fill_lanes(64, 5), 2'd2, 3, 1'b0, '0, 1'b0, 1'b0);
    do_op(fill_lanes(64, 5), 2'd2, 0, 1'b1, '0, 1'b1, 1'b0);
    do_op(fill_lanes(64, 6), 2'd3, 2, 1'b0, '0, 1'b1, 1'b0);
    do_op('0, 2'd0, 3, 1'b0, '0, 1'b0, 1'b1);

    // Random shifted/inverted operands with varied control
    for (int n = 0; n < 2400; n++) begin
      sv = '0;
      for (int j = 0; j < 2; j++) begin
        logic [63:0] x;
        x = {$urandom, $urandom};
        x = x >> ($urandom % 64);
        if ($urandom % 2 == 1) x = ~x;
        sv[j*64 +: 64] = x;
      end
      do_op(sv, 2'($urandom % 4), int'($urandom % 4), 1'($urandom % 2),
            {$urandom, $urandom}, ($urandom % 8) != 0, ($urandom % 4) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule